// File: doc/BRIEF.md
# Source Operand Evaluation Sequencer

This block is the control sequencer for the source-operand phase of a 16-bit two-operand processor instruction. After decode it receives a start pulse together with the 2-bit source addressing mode, the 4-bit source register number and a byte/word flag. It then walks through a short, mode-dependent sequence of clock steps. During those steps it reads the register file, issues memory reads, bumps the program counter past extension words and writes back auto-incremented registers. At the end it loads the ALU source latch and pulses `done_o` so that destination evaluation can begin.

Three registers change the meaning of the base modes. R0 is the program counter: indexed mode becomes PC-relative, and auto-increment becomes an immediate fetch. R2 is the status register: indexed mode becomes absolute with a zero base, and the indirect modes produce the constants 4 and 8. R3 is a pure constant source. The number of steps is fixed for each resolved mode.

The memory is a synchronous read port: the word addressed in one cycle on `mem_rd_o`/`mem_addr_o` is valid on `mem_rdata_i` in the next cycle. The register file reads combinationally. The operand is always delivered as a full word, and the byte flag affects only the auto-increment amount.

Top module: `src_operand_seq`

## Requirements
- R1: Mode 00 with any register other than R3 takes 1 step and delivers the register-file value for that register. This includes R0, which gives the current PC, and R2, which gives the status register contents.
- R2: R3 in modes 00, 01, 10 and 11 yields 0x0000, 0x0001, 0x0002 and 0xFFFF. R2 in modes 10 and 11 yields 0x0004 and 0x0008. Each constant takes 1 step with no memory read and no PC change.
- R3: Mode 10 (register indirect) delivers the memory word at the register's value in 2 steps with exactly one memory read.
- R4: Mode 11 with a register other than R0, R2 or R3 delivers the memory word at the register's old value in 2 steps. It writes the register back increased by 2 for words or by 1 when the byte flag is 1.
- R5: Mode 11 with R0 (immediate) delivers the memory word at the PC in 2 steps, with one memory read and a PC advance of 2.
- R6: Mode 01 with R2 (absolute) reads the extension word at the PC and then delivers the memory word at that address. It takes 3 steps, two reads and a PC advance of 2.
- R7: Mode 01 with a register other than R0, R2 or R3 (indexed) delivers the memory word at (extension word + register value). It takes 4 steps, two reads and a PC advance of 2.
- R8: Mode 01 with R0 (PC-relative) delivers the memory word at (extension word + address of the extension word). It takes 4 steps, two reads and a PC advance of 2.
- R9: If a start is accepted at a clock edge and the mode needs N steps, `done_o` is high for exactly one cycle, N+1 cycles after the start cycle. From then on, `src_o` holds the operand until the next operand is loaded.
- R10: A start pulse arriving while a sequence is in progress is ignored. The running operand, its step count, its reads and its PC advance are unchanged.
- R11: During and after reset, `done_o`, `mem_rd_o`, `pc_inc_o` and `rf_we_o` are low and `src_o` is zero. A reset in the middle of a sequence abandons it without a later `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin source evaluation (accepted only when idle) |
| mode_i | input | 2 | Source addressing mode |
| src_reg_i | input | 4 | Source register number |
| byte_i | input | 1 | 1 = byte operation, 0 = word |
| pc_i | input | 16 | Current program counter |
| pc_inc_o | output | 1 | Advance the PC by 2 at this edge |
| mem_rd_o | output | 1 | Memory read request |
| mem_addr_o | output | 16 | Memory read address |
| mem_rdata_i | input | 16 | Read data, valid the cycle after a request |
| rf_rsel_o | output | 4 | Register-file read select |
| rf_rdata_i | input | 16 | Register-file read data |
| rf_we_o | output | 1 | Register-file write enable |
| rf_wsel_o | output | 4 | Register-file write select |
| rf_wdata_o | output | 16 | Register-file write data |
| src_load_o | output | 1 | ALU source latch loads this cycle |
| src_o | output | 16 | ALU source latch contents |
| done_o | output | 1 | One-cycle operand-ready pulse |

## Verification
A wrong step counter or a wrongly resolved mode shows up as a `done_o` pulse that comes too early or too late. It also shows up as a missing or extra memory read, or as a PC that advances when it should not. Any of these is visible within the four steps of a single operand. A corrupted temporary address register shows up at `src_o` in the `done_o` cycle of that same operand, because the expected memory word differs. A latched start that was not properly blocked while busy changes the operand or the step count of the sequence already running, which is visible at its own `done_o`.

// File: rtl/sos_pkg.sv
`timescale 1ns/1ps
package sos_pkg;

   // Resolved operand kinds after special-register reinterpretation
   typedef enum logic [2:0] {
      K_REG   = 3'd0,
      K_CONST = 3'd1,
      K_IND   = 3'd2,
      K_AUTO  = 3'd3,
      K_IMM   = 3'd4,
      K_ABS   = 3'd5,
      K_IDX   = 3'd6
   } kind_e;

   localparam logic [1:0] AM_DIRECT = 2'b00;
   localparam logic [1:0] AM_OFFSET = 2'b01;
   localparam logic [1:0] AM_DEREF  = 2'b10;
   localparam logic [1:0] AM_POSTI  = 2'b11;

   // Number of clock steps each resolved kind occupies
   function automatic logic [2:0] kind_steps(input kind_e k);
      case (k)
         K_REG, K_CONST:      return 3'd1;
         K_IND, K_AUTO, K_IMM: return 3'd2;
         K_ABS:               return 3'd3;
         default:             return 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/sos_decode.sv
`timescale 1ns/1ps
module sos_decode import sos_pkg::*; #(
   parameter int DW     = 16,
   parameter int RSW    = 4,
   parameter int PC_IDX = 0,
   parameter int SR_IDX = 2,
   parameter int CG_IDX = 3,
   parameter bit CG_EN  = 1'b1
) (
   input  logic [1:0]     mode_i,
   input  logic [RSW-1:0] reg_i,
   output kind_e          kind_o,
   output logic [DW-1:0]  cval_o
);

   logic cg_hit;

   generate
      if (CG_EN) begin : g_cg
         always_comb begin
            cg_hit = 1'b0;
            cval_o = '0;
            if (reg_i == RSW'(CG_IDX)) begin
               cg_hit = 1'b1;
               case (mode_i)
                  AM_DIRECT: cval_o = '0;
                  AM_OFFSET: cval_o = DW'(1);
                  AM_DEREF:  cval_o = DW'(2);
                  default:   cval_o = '1;
               endcase
            end else if (reg_i == RSW'(SR_IDX) && mode_i[1]) begin
               cg_hit = 1'b1;
               cval_o = mode_i[0] ? DW'(8) : DW'(4);
            end
         end
      end else begin : g_nocg
         assign cg_hit = 1'b0;
         assign cval_o = '0;
      end
   endgenerate

   always_comb begin
      if (cg_hit) begin
         kind_o = K_CONST;
      end else begin
         case (mode_i)
            AM_DIRECT: kind_o = K_REG;
            AM_OFFSET: kind_o = (reg_i == RSW'(SR_IDX)) ? K_ABS : K_IDX;
            AM_DEREF:  kind_o = K_IND;
            default:   kind_o = (reg_i == RSW'(PC_IDX)) ? K_IMM : K_AUTO;
         endcase
      end
   end

endmodule

// File: rtl/sos_seq.sv
`timescale 1ns/1ps
module sos_seq import sos_pkg::*; #(
   parameter int DW     = 16,
   parameter int RSW    = 4,
   parameter int PC_IDX = 0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start_i,
   input  kind_e          kind_i,
   input  logic [DW-1:0]  cval_i,
   input  logic [RSW-1:0] reg_i,
   input  logic           byte_i,
   input  logic [DW-1:0]  pc_i,
   input  logic [DW-1:0]  mem_rdata_i,
   input  logic [DW-1:0]  rf_rdata_i,
   output logic           pc_inc_o,
   output logic           mem_rd_o,
   output logic [DW-1:0]  mem_addr_o,
   output logic [RSW-1:0] rf_rsel_o,
   output logic           rf_we_o,
   output logic [RSW-1:0] rf_wsel_o,
   output logic [DW-1:0]  rf_wdata_o,
   output logic           src_load_o,
   output logic [DW-1:0]  src_o,
   output logic           done_o
);

   logic           busy_q;
   logic [2:0]     step_q;
   kind_e          kind_q;
   logic [RSW-1:0] reg_q;
   logic           byte_q;
   logic [DW-1:0]  cval_q, tmp_q, tmp_d, src_q, load_val;
   logic           done_q, tmp_we;

   always_comb begin
      pc_inc_o   = 1'b0;
      mem_rd_o   = 1'b0;
      mem_addr_o = '0;
      rf_rsel_o  = reg_q;
      rf_we_o    = 1'b0;
      rf_wsel_o  = reg_q;
      rf_wdata_o = rf_rdata_i + (byte_q ? DW'(1) : DW'(2));
      src_load_o = 1'b0;
      load_val   = mem_rdata_i;
      tmp_we     = 1'b0;
      tmp_d      = tmp_q;
      if (busy_q) begin
         case (kind_q)
            K_REG: begin
               src_load_o = 1'b1;
               load_val   = rf_rdata_i;
            end
            K_CONST: begin
               src_load_o = 1'b1;
               load_val   = cval_q;
            end
            K_IND, K_AUTO: begin
               if (step_q == 3'd1) begin
                  mem_rd_o   = 1'b1;
                  mem_addr_o = rf_rdata_i;
                  rf_we_o    = (kind_q == K_AUTO);
               end else begin
                  src_load_o = 1'b1;
               end
            end
            K_IMM: begin
               if (step_q == 3'd1) begin
                  mem_rd_o   = 1'b1;
                  mem_addr_o = pc_i;
                  pc_inc_o   = 1'b1;
               end else begin
                  src_load_o = 1'b1;
               end
            end
            K_ABS: begin
               case (step_q)
                  3'd1: begin
                     mem_rd_o   = 1'b1;
                     mem_addr_o = pc_i;
                     pc_inc_o   = 1'b1;
                  end
                  3'd2: begin
                     mem_rd_o   = 1'b1;
                     mem_addr_o = mem_rdata_i;
                  end
                  default: src_load_o = 1'b1;
               endcase
            end
            default: begin
               case (step_q)
                  3'd1: begin
                     mem_rd_o   = 1'b1;
                     mem_addr_o = pc_i;
                     pc_inc_o   = 1'b1;
                     tmp_we     = 1'b1;
                     tmp_d      = (reg_q == RSW'(PC_IDX)) ? pc_i : rf_rdata_i;
                  end
                  3'd2: begin
                     tmp_we = 1'b1;
                     tmp_d  = mem_rdata_i + tmp_q;
                  end
                  3'd3: begin
                     mem_rd_o   = 1'b1;
                     mem_addr_o = tmp_q;
                  end
                  default: src_load_o = 1'b1;
               endcase
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         step_q <= 3'd0;
         kind_q <= K_REG;
         reg_q  <= '0;
         byte_q <= 1'b0;
         cval_q <= '0;
         tmp_q  <= '0;
         src_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= src_load_o;
         if (tmp_we) tmp_q <= tmp_d;
         if (src_load_o) src_q <= load_val;
         if (!busy_q) begin
            if (start_i) begin
               busy_q <= 1'b1;
               step_q <= 3'd1;
               kind_q <= kind_i;
               reg_q  <= reg_i;
               byte_q <= byte_i;
               cval_q <= cval_i;
            end
         end else if (src_load_o) begin
            busy_q <= 1'b0;
            step_q <= 3'd0;
         end else begin
            step_q <= step_q + 3'd1;
         end
      end
   end

   assign src_o  = src_q;
   assign done_o = done_q;

   AST_CONST_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && kind_q == K_CONST) |-> (!mem_rd_o && !pc_inc_o)); // R2
   AST_WE_ONLY_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we_o |-> (kind_q == K_AUTO && step_q == 3'd1 && mem_rd_o)); // R4
   AST_PC_INC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      pc_inc_o |=> !pc_inc_o); // R5
   AST_LOAD_AT_LAST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      src_load_o |-> (step_q == kind_steps(kind_q))); // R9
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R9
   AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !src_load_o && start_i) |=> (kind_q == $past(kind_q) && busy_q)); // R10

endmodule

// File: rtl/src_operand_seq.sv
`timescale 1ns/1ps
module src_operand_seq import sos_pkg::*; #(
   parameter int DW     = 16,
   parameter int RSW    = 4,
   parameter int PC_IDX = 0,
   parameter int SR_IDX = 2,
   parameter int CG_IDX = 3,
   parameter bit CG_EN  = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start_i,
   input  logic [1:0]     mode_i,
   input  logic [RSW-1:0] src_reg_i,
   input  logic           byte_i,
   input  logic [DW-1:0]  pc_i,
   output logic           pc_inc_o,
   output logic           mem_rd_o,
   output logic [DW-1:0]  mem_addr_o,
   input  logic [DW-1:0]  mem_rdata_i,
   output logic [RSW-1:0] rf_rsel_o,
   input  logic [DW-1:0]  rf_rdata_i,
   output logic           rf_we_o,
   output logic [RSW-1:0] rf_wsel_o,
   output logic [DW-1:0]  rf_wdata_o,
   output logic           src_load_o,
   output logic [DW-1:0]  src_o,
   output logic           done_o
);

   localparam int NREG = 1 << RSW;

   initial begin
      assert (DW >= 8) else $error("DW must be at least 8");
      assert (PC_IDX < NREG && SR_IDX < NREG && CG_IDX < NREG)
         else $error("special register index out of range");
      assert (PC_IDX != SR_IDX && PC_IDX != CG_IDX && SR_IDX != CG_IDX)
         else $error("special register indices must differ");
   end

   kind_e         kind;
   logic [DW-1:0] cval;

   sos_decode #(
      .DW(DW), .RSW(RSW), .PC_IDX(PC_IDX), .SR_IDX(SR_IDX),
      .CG_IDX(CG_IDX), .CG_EN(CG_EN)
   ) u_decode (
      .mode_i (mode_i),
      .reg_i  (src_reg_i),
      .kind_o (kind),
      .cval_o (cval)
   );

   sos_seq #(.DW(DW), .RSW(RSW), .PC_IDX(PC_IDX)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .kind_i      (kind),
      .cval_i      (cval),
      .reg_i       (src_reg_i),
      .byte_i      (byte_i),
      .pc_i        (pc_i),
      .mem_rdata_i (mem_rdata_i),
      .rf_rdata_i  (rf_rdata_i),
      .pc_inc_o    (pc_inc_o),
      .mem_rd_o    (mem_rd_o),
      .mem_addr_o  (mem_addr_o),
      .rf_rsel_o   (rf_rsel_o),
      .rf_we_o     (rf_we_o),
      .rf_wsel_o   (rf_wsel_o),
      .rf_wdata_o  (rf_wdata_o),
      .src_load_o  (src_load_o),
      .src_o       (src_o),
      .done_o      (done_o)
   );

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |-> (!done_o && !mem_rd_o && !pc_inc_o && !rf_we_o)); // R11

endmodule

// File: tb/tb_src_operand_seq.sv
`timescale 1ns/1ps
module tb_src_operand_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  mode = 2'b00;
   logic [3:0]  sreg = 4'd0;
   logic        byt = 1'b0;
   logic [15:0] pc_m;
   logic        pc_inc, mem_rd, rf_we, src_load, done;
   logic [15:0] mem_addr, mem_q, rf_wdata, src, rf_rdata;
   logic [3:0]  rf_rsel, rf_wsel;
   logic [15:0] rf [16];
   int          rd_cnt;
   int          tests = 0;
   int          fails = 0;

   always #2.5 clk = ~clk;

   src_operand_seq dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode),
      .src_reg_i(sreg), .byte_i(byt), .pc_i(pc_m), .pc_inc_o(pc_inc),
      .mem_rd_o(mem_rd), .mem_addr_o(mem_addr), .mem_rdata_i(mem_q),
      .rf_rsel_o(rf_rsel), .rf_rdata_i(rf_rdata), .rf_we_o(rf_we),
      .rf_wsel_o(rf_wsel), .rf_wdata_o(rf_wdata), .src_load_o(src_load),
      .src_o(src), .done_o(done)
   );

   function automatic logic [15:0] memf(input logic [15:0] a);
      return (a ^ 16'h5A3C) + {a[7:0], a[15:8]};
   endfunction

   // Environment model: synchronous memory, register file (R0 reads PC), PC
   assign rf_rdata = (rf_rsel == 4'd0) ? pc_m : rf[rf_rsel];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 16; i++) rf[i] <= 16'h0200 + 16'(i) * 16'h0022;
         rf[2]  <= 16'h0107;
         pc_m   <= 16'h8000;
         mem_q  <= 16'h0000;
         rd_cnt <= 0;
      end else begin
         if (mem_rd) begin
            mem_q  <= memf(mem_addr);
            rd_cnt <= rd_cnt + 1;
         end
         if (rf_we) rf[rf_wsel] <= rf_wdata;
         if (pc_inc) pc_m <= pc_m + 16'd2;
      end
   end

   task automatic chk(input int req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] regv(input logic [3:0] r);
      return (r == 4'd0) ? pc_m : rf[r];
   endfunction

   // Expected operand, computed from the addressing rules
   function automatic logic [15:0] expect_val(input logic [1:0] m, input logic [3:0] r);
      if (r == 4'd3) begin
         case (m)
            2'b00: return 16'h0000;
            2'b01: return 16'h0001;
            2'b10: return 16'h0002;
            default: return 16'hFFFF;
         endcase
      end
      if (r == 4'd2 && m[1]) return m[0] ? 16'h0008 : 16'h0004;
      case (m)
         2'b00: return regv(r);
         2'b01: begin
            if (r == 4'd2) return memf(memf(pc_m));
            if (r == 4'd0) return memf(memf(pc_m) + pc_m);
            return memf(memf(pc_m) + rf[r]);
         end
         default: return (r == 4'd0) ? memf(pc_m) : memf(rf[r]);
      endcase
   endfunction

   task automatic run_op(input int req, input logic [1:0] m, input logic [3:0] r,
                         input logic b, input int steps, input int reads,
                         input int pcd, input bit mid_start);
      logic [15:0] ev, old_pc, old_r;
      int rd0, cnt;
      ev = expect_val(m, r);
      old_pc = pc_m;
      old_r = rf[r];
      rd0 = rd_cnt;
      @(negedge clk);
      mode = m; sreg = r; byt = b; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cnt = 1;
      if (mid_start) begin
         // foreign start while busy (R10)
         start = 1'b1; mode = 2'b00; sreg = 4'd5; byt = 1'b1;
      end
      while (!done && cnt < 12) begin
         @(negedge clk);
         start = 1'b0;
         cnt++;
      end
      chk(req, "done latency (steps+1)", cnt, steps + 1);
      chk(req, "operand value", src, ev);
      chk(req, "memory reads", rd_cnt - rd0, reads);
      chk(req, "pc advance", pc_m - old_pc, pcd);
      if (m == 2'b11 && r != 4'd0 && r != 4'd2 && r != 4'd3)
         chk(4, "auto-increment writeback", rf[r], old_r + (b ? 16'd1 : 16'd2));
      @(negedge clk);
      chk(9, "done single cycle", done, 1'b0);
      chk(9, "operand held", src, ev);
   endtask

   // {req, mode, reg, byte, steps, reads, pc_advance/2}
   localparam logic [16:0] VEC [16] = '{
      {4'd1, 2'b00, 4'd5, 1'b0, 3'd1, 2'd0, 1'b0},  // R1 plain register
      {4'd1, 2'b00, 4'd2, 1'b0, 3'd1, 2'd0, 1'b0},  // R1 status register
      {4'd1, 2'b00, 4'd0, 1'b0, 3'd1, 2'd0, 1'b0},  // R1 PC value
      {4'd2, 2'b00, 4'd3, 1'b0, 3'd1, 2'd0, 1'b0},  // R2 const 0
      {4'd2, 2'b01, 4'd3, 1'b0, 3'd1, 2'd0, 1'b0},  // R2 const 1
      {4'd2, 2'b10, 4'd3, 1'b0, 3'd1, 2'd0, 1'b0},  // R2 const 2
      {4'd2, 2'b11, 4'd3, 1'b0, 3'd1, 2'd0, 1'b0},  // R2 const -1
      {4'd2, 2'b10, 4'd2, 1'b0, 3'd1, 2'd0, 1'b0},  // R2 const 4
      {4'd2, 2'b11, 4'd2, 1'b1, 3'd1, 2'd0, 1'b0},  // R2 const 8
      {4'd3, 2'b10, 4'd6, 1'b0, 3'd2, 2'd1, 1'b0},  // R3 indirect
      {4'd4, 2'b11, 4'd7, 1'b0, 3'd2, 2'd1, 1'b0},  // R4 auto-inc word
      {4'd4, 2'b11, 4'd8, 1'b1, 3'd2, 2'd1, 1'b0},  // R4 auto-inc byte
      {4'd5, 2'b11, 4'd0, 1'b0, 3'd2, 2'd1, 1'b1},  // R5 immediate
      {4'd6, 2'b01, 4'd2, 1'b0, 3'd3, 2'd2, 1'b1},  // R6 absolute
      {4'd7, 2'b01, 4'd9, 1'b0, 3'd4, 2'd2, 1'b1},  // R7 indexed
      {4'd8, 2'b01, 4'd0, 1'b0, 3'd4, 2'd2, 1'b1}   // R8 PC-relative
   };

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(11, "reset done", done, 1'b0);
      chk(11, "reset mem_rd", mem_rd, 1'b0);
      chk(11, "reset pc_inc", pc_inc, 1'b0);
      chk(11, "reset rf_we", rf_we, 1'b0);
      chk(11, "reset src", src, 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < 16; i++) begin
         logic [16:0] v;
         v = VEC[i];
         run_op(int'(v[16:13]), v[12:11], v[10:7], v[6], int'(v[5:3]),
                int'(v[2:1]), v[0] ? 2 : 0, 1'b0);
      end

      // R10: start during an indexed sequence is ignored
      run_op(10, 2'b01, 4'd9, 1'b0, 4, 2, 2, 1'b1);
      // R10: start during an immediate sequence is ignored
      run_op(10, 2'b11, 4'd0, 1'b0, 2, 1, 2, 1'b1);

      // R11: reset in the middle of an indexed sequence abandons it
      @(negedge clk);
      mode = 2'b01; sreg = 4'd9; byt = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(11, "mid-op reset mem_rd", mem_rd, 1'b0);
      chk(11, "mid-op reset pc_inc", pc_inc, 1'b0);
      rst_n = 1'b1;
      begin
         int seen;
         seen = 0;
         for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (done) seen++;
         end
         chk(11, "no done after mid-op reset", seen, 0);
      end
      chk(11, "src cleared by reset", src, 16'h0000);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule